// File: doc/BRIEF.md
# Rotating Register Window Controller

This block keeps the bookkeeping for a windowed register file: a physical file of `NAREG` registers (32 or 64) of which sixteen are visible at any time through a window that slides in steps of four registers. It holds the window base (a group number modulo `NAREG/4`) and a live-group mask with one bit per four-register group. It maps visible register numbers to physical ones and carries out the window operations of a call/return scheme: function entry, the overflow check made before a register group is touched, windowed return, signed rotate, restore of a saved base, direct base write and the stack-move check.

Each operation is presented for one cycle with `op_valid`. The base and mask change at that clock edge, and the results appear for exactly one cycle after the same edge: an exception request with a type code and the faulting PC, a request to update the saved-base status field, a register write (physical index and data) for entry, or a return target for a clean return. The status bits (overflow enable, exception mode, call increment, saved base) come in as inputs. Raising exception mode is left to the exception unit that accepts `exc_valid`. The register data itself is stored elsewhere.

Top module: `rwc_window_ctrl`

## Requirements
- R1: After reset the base is 0 and the live mask holds only bit 0. The mask is never empty afterwards.
- R2: `map_pidx` is combinational and equals (base*4 + `map_vidx`) modulo `NAREG`, so a window may wrap past the top of the file.
- R3: Entry (`op_code` 1) is illegal when `op_s` > 3, when `st_woe` is 0 or when `st_excm` is 1. It then raises code 1 (illegal) and leaves the base and the mask unchanged.
- R4: A legal entry writes `op_sp` - 8*`op_imm` to the physical register that maps visible register `st_callinc`*4 + `op_s` under the old base. It advances the base by `st_callinc` and sets the mask bit of the new base.
- R5: The overflow check (`op_code` 2, group count w = `op_imm[1:0]`) acts only when `st_woe` is 1 and `st_excm` is 0. It looks for the smallest n in 1..w whose mask bit at base+n is set. If there is none, nothing changes and nothing is reported.
- R6: When that n exists, the base advances by n to m, `owb_val` carries the old base with `owb_we`, and the exception code is 3 if the bit at m+1 is set, 4 if the bit at m+2 is set, and 5 otherwise.
- R7: Return (`op_code` 3) takes n = `op_a0[31:30]` and m = the first of base-1, base-2, base-3 with a set mask bit (0 if none). It raises code 1 if n = 0, if m is not 0 and differs from n, or if the mode is wrong (overflow enable clear or exception mode set).
- R8: A legal return moves the base back by n. If the new base's bit is set, the old base's bit is cleared and `ret_pc` = {`op_pc[31:30]`, `op_a0[29:0]`} is presented with `ret_valid`.
- R9: If after a legal return the new base's bit is clear, the base still moves, the mask is unchanged, the old base goes out through `owb_we`, and the code is 6, 7 or 8 for n = 1, 2 or 3.
- R10: The stack-move check (`op_code` 6) raises code 2 when the mask bits at base-1, base-2 and base-3 are all clear, and otherwise does nothing.
- R11: Rotate (`op_code` 4) adds the signed value `op_imm[3:0]` to the base. Restore (`op_code` 5) loads the base from `st_owb`, and set-base (`op_code` 7) loads it from `op_imm`. All base arithmetic wraps modulo `NAREG/4`.
- R12: With `op_valid` low, or with `op_code` 0, the state holds and no result pulses. Results last one cycle, and at most one of `exc_valid`, `wr_en` and `ret_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 3 | Operation select |
| op_s | input | 4 | Stack register index for entry |
| op_imm | input | 12 | Immediate: frame size, group count, rotate amount or base |
| op_sp | input | 32 | Stack register value |
| op_a0 | input | 32 | Visible register 0 value (return address) |
| op_pc | input | 32 | PC of the operation |
| st_woe | input | 1 | Overflow-enable status bit |
| st_excm | input | 1 | Exception-mode status bit |
| st_callinc | input | 2 | Call increment status field |
| st_owb | input | log2(NAREG/4) | Saved-base status field |
| map_vidx | input | 4 | Visible register to translate |
| map_pidx | output | log2(NAREG) | Physical register index |
| win_base | output | log2(NAREG/4) | Current window base |
| win_start | output | NAREG/4 | Live-group mask |
| exc_valid | output | 1 | Exception request pulse |
| exc_code | output | 4 | Exception type |
| exc_pc | output | 32 | PC saved with the exception |
| owb_we | output | 1 | Saved-base field write pulse |
| owb_val | output | log2(NAREG/4) | Value for the saved-base field |
| wr_en | output | 1 | Register write pulse from entry |
| wr_idx | output | log2(NAREG) | Physical register written |
| wr_data | output | 32 | Data written |
| ret_valid | output | 1 | Clean return pulse |
| ret_pc | output | 32 | Return target |

## Verification
The combinational index mapping and a base move can fall in the same cycle. The mapping reads the base as it stands before the edge, while a rotate issued in that cycle changes it at the edge. The bench holds `map_vidx` fixed, issues a rotate, and samples `map_pidx` once before the capturing edge (old base expected) and once after it (new base expected). A return that underflows also combines a base move with an exception in one edge. The bench checks that both the moved base and the code tied to n appear in the same result cycle.

// File: rtl/rwc_pkg.sv
package rwc_pkg;
  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_ENTRY   = 3'd1,
    OP_OVCHK   = 3'd2,
    OP_RETW    = 3'd3,
    OP_ROT     = 3'd4,
    OP_RESTORE = 3'd5,
    OP_SPCHK   = 3'd6,
    OP_SETBASE = 3'd7
  } rwc_op_e;

  typedef enum logic [3:0] {
    EX_NONE    = 4'd0,
    EX_ILLEGAL = 4'd1,
    EX_ALLOCA  = 4'd2,
    EX_OVF4    = 4'd3,
    EX_OVF8    = 4'd4,
    EX_OVF12   = 4'd5,
    EX_UNF4    = 4'd6,
    EX_UNF8    = 4'd7,
    EX_UNF12   = 4'd8
  } rwc_exc_e;
endpackage

// File: rtl/rwc_index_map.sv
module rwc_index_map #(
  parameter int NAREG = 64,
  localparam int GW = $clog2(NAREG / 4),
  localparam int PW = $clog2(NAREG)
) (
  input  logic [GW-1:0] base,
  input  logic [3:0]    vidx,
  output logic [PW-1:0] pidx
);
  // group*4 is exactly PW bits wide; the sum wraps modulo NAREG
  assign pidx = {base, 2'b00} + {{(PW-4){1'b0}}, vidx};
endmodule

// File: rtl/rwc_window_scan.sv
module rwc_window_scan #(
  parameter int NAREG = 64,
  localparam int NG = NAREG / 4,
  localparam int GW = $clog2(NG)
) (
  input  logic [GW-1:0] base,
  input  logic [NG-1:0] live,
  input  logic [1:0]    lim,
  output logic          fwd_hit,
  output logic [1:0]    fwd_n,
  output logic [1:0]    fwd_kind,
  output logic [1:0]    back_m
);
  logic [GW-1:0] m_grp;

  // forward search: smallest n in 1..lim with a live group at base+n
  always_comb begin
    fwd_hit = 1'b0;
    fwd_n   = 2'd0;
    for (int k = 3; k >= 1; k--) begin
      if ((k <= int'(lim)) && live[base + GW'(k)]) begin
        fwd_hit = 1'b1;
        fwd_n   = 2'(k);
      end
    end
  end

  assign m_grp = base + GW'(fwd_n);

  // frame size of the spilled caller: 0 -> 4 regs, 1 -> 8, 2 -> 12
  always_comb begin
    if (live[m_grp + GW'(1)])      fwd_kind = 2'd0;
    else if (live[m_grp + GW'(2)]) fwd_kind = 2'd1;
    else                           fwd_kind = 2'd2;
  end

  // backward search: nearest live group below the base
  always_comb begin
    back_m = 2'd0;
    for (int k = 3; k >= 1; k--) begin
      if (live[base - GW'(k)]) back_m = 2'(k);
    end
  end
endmodule

// File: rtl/rwc_window_ctrl.sv
module rwc_window_ctrl
  import rwc_pkg::*;
#(
  parameter int NAREG = 64,
  localparam int NG = NAREG / 4,
  localparam int GW = $clog2(NG),
  localparam int PW = $clog2(NAREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [2:0]    op_code,
  input  logic [3:0]    op_s,
  input  logic [11:0]   op_imm,
  input  logic [31:0]   op_sp,
  input  logic [31:0]   op_a0,
  input  logic [31:0]   op_pc,
  input  logic          st_woe,
  input  logic          st_excm,
  input  logic [1:0]    st_callinc,
  input  logic [GW-1:0] st_owb,
  input  logic [3:0]    map_vidx,
  output logic [PW-1:0] map_pidx,
  output logic [GW-1:0] win_base,
  output logic [NG-1:0] win_start,
  output logic          exc_valid,
  output logic [3:0]    exc_code,
  output logic [31:0]   exc_pc,
  output logic          owb_we,
  output logic [GW-1:0] owb_val,
  output logic          wr_en,
  output logic [PW-1:0] wr_idx,
  output logic [31:0]   wr_data,
  output logic          ret_valid,
  output logic [31:0]   ret_pc
);
  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i = rst_pipe[1];

  logic [GW-1:0] base_q, base_d;
  logic [NG-1:0] live_q, live_d;
  logic          st_en;

  logic          exc_d, owe_d, wen_d, rv_d;
  rwc_exc_e      code_d;
  logic [31:0]   epc_d, wdata_d, rpc_d;
  logic [GW-1:0] owb_d;
  logic [PW-1:0] widx_d, ent_pidx;

  logic          fwd_hit;
  logic [1:0]    fwd_n, fwd_kind, back_m, ret_n;
  logic          mode_ok;
  logic [7:0]    rot_ext;
  rwc_op_e       op;

  rwc_index_map #(.NAREG(NAREG)) u_map_port (
    .base(base_q), .vidx(map_vidx), .pidx(map_pidx)
  );

  rwc_index_map #(.NAREG(NAREG)) u_map_entry (
    .base(base_q), .vidx({st_callinc, op_s[1:0]}), .pidx(ent_pidx)
  );

  rwc_window_scan #(.NAREG(NAREG)) u_scan (
    .base(base_q), .live(live_q), .lim(op_imm[1:0]),
    .fwd_hit(fwd_hit), .fwd_n(fwd_n), .fwd_kind(fwd_kind), .back_m(back_m)
  );

  assign op      = rwc_op_e'(op_code);
  assign mode_ok = st_woe & ~st_excm;
  assign ret_n   = op_a0[31:30];
  assign rot_ext = {{4{op_imm[3]}}, op_imm[3:0]};
  assign st_en   = op_valid;

  always_comb begin
    base_d  = base_q;
    live_d  = live_q;
    exc_d   = 1'b0;
    code_d  = EX_NONE;
    epc_d   = '0;
    owe_d   = 1'b0;
    owb_d   = '0;
    wen_d   = 1'b0;
    widx_d  = '0;
    wdata_d = '0;
    rv_d    = 1'b0;
    rpc_d   = '0;
    if (op_valid) begin
      unique case (op)
        OP_ENTRY: begin
          if ((op_s > 4'd3) || !mode_ok) begin
            exc_d  = 1'b1;
            code_d = EX_ILLEGAL;
          end else begin
            wen_d   = 1'b1;
            widx_d  = ent_pidx;
            wdata_d = op_sp - {17'd0, op_imm, 3'd0};
            base_d  = base_q + GW'(st_callinc);
            live_d[base_d] = 1'b1;
          end
        end
        OP_OVCHK: begin
          if (mode_ok && fwd_hit) begin
            base_d = base_q + GW'(fwd_n);
            owe_d  = 1'b1;
            owb_d  = base_q;
            exc_d  = 1'b1;
            unique case (fwd_kind)
              2'd0:    code_d = EX_OVF4;
              2'd1:    code_d = EX_OVF8;
              default: code_d = EX_OVF12;
            endcase
          end
        end
        OP_RETW: begin
          if ((ret_n == 2'd0) || ((back_m != 2'd0) && (back_m != ret_n)) || !mode_ok) begin
            exc_d  = 1'b1;
            code_d = EX_ILLEGAL;
          end else begin
            base_d = base_q - GW'(ret_n);
            if (live_q[base_d]) begin
              live_d[base_q] = 1'b0;
              rv_d  = 1'b1;
              rpc_d = {op_pc[31:30], op_a0[29:0]};
            end else begin
              owe_d = 1'b1;
              owb_d = base_q;
              exc_d = 1'b1;
              unique case (ret_n)
                2'd1:    code_d = EX_UNF4;
                2'd2:    code_d = EX_UNF8;
                default: code_d = EX_UNF12;
              endcase
            end
          end
        end
        OP_ROT:     base_d = base_q + rot_ext[GW-1:0];
        OP_RESTORE: base_d = st_owb;
        OP_SPCHK: begin
          if (back_m == 2'd0) begin
            exc_d  = 1'b1;
            code_d = EX_ALLOCA;
          end
        end
        OP_SETBASE: base_d = op_imm[GW-1:0];
        default: ;
      endcase
      if (exc_d) epc_d = op_pc;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      base_q <= '0;
      live_q <= NG'(1);
    end else if (st_en) begin
      base_q <= base_d;
      live_q <= live_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      exc_valid <= 1'b0;
      exc_code  <= '0;
      exc_pc    <= '0;
      owb_we    <= 1'b0;
      owb_val   <= '0;
      wr_en     <= 1'b0;
      wr_idx    <= '0;
      wr_data   <= '0;
      ret_valid <= 1'b0;
      ret_pc    <= '0;
    end else begin
      exc_valid <= exc_d;
      exc_code  <= code_d;
      exc_pc    <= epc_d;
      owb_we    <= owe_d;
      owb_val   <= owb_d;
      wr_en     <= wen_d;
      wr_idx    <= widx_d;
      wr_data   <= wdata_d;
      ret_valid <= rv_d;
      ret_pc    <= rpc_d;
    end
  end

  assign win_base  = base_q;
  assign win_start = live_q;
endmodule

// File: rtl/rwc_window_ctrl_chk.sv
module rwc_window_ctrl_chk #(
  parameter int NAREG = 64,
  localparam int NG = NAREG / 4,
  localparam int GW = $clog2(NG)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic [2:0]    op_code,
  input logic [3:0]    op_s,
  input logic [1:0]    a0_top,
  input logic          st_woe,
  input logic          st_excm,
  input logic [3:0]    vidx,
  input logic [1:0]    map_lo,
  input logic [GW-1:0] win_base,
  input logic [NG-1:0] win_start,
  input logic          exc_valid,
  input logic [3:0]    exc_code,
  input logic          owb_we,
  input logic          wr_en,
  input logic          ret_valid
);
  assert_mask_live_R1: assert property (@(posedge clk) disable iff (!rst_n)
    win_start != '0);

  assert_map_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    map_lo == vidx[1:0]);

  assert_bad_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == 3'd1 && (op_s > 4'd3 || !st_woe || st_excm)
    |=> exc_valid && exc_code == 4'd1 && $stable(win_base) && $stable(win_start));

  assert_entry_mark_R4: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == 3'd1 && op_s <= 4'd3 && st_woe && !st_excm
    |=> wr_en && win_start[win_base]);

  assert_spill_owb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid && exc_code >= 4'd3 && exc_code <= 4'd5 |-> owb_we);

  assert_ret_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == 3'd3 && a0_top == 2'd0 |=> exc_valid && exc_code == 4'd1);

  assert_fill_owb_R9: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid && exc_code >= 4'd6 |-> owb_we && $stable(win_start));

  assert_one_result_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({exc_valid, wr_en, ret_valid}));

  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(win_base) && $stable(win_start) && !exc_valid && !wr_en && !ret_valid);
endmodule

bind rwc_window_ctrl rwc_window_ctrl_chk #(.NAREG(NAREG)) u_chk (
  .clk(clk), .rst_n(rst_i), .op_valid(op_valid), .op_code(op_code), .op_s(op_s),
  .a0_top(op_a0[31:30]), .st_woe(st_woe), .st_excm(st_excm), .vidx(map_vidx),
  .map_lo(map_pidx[1:0]), .win_base(win_base), .win_start(win_start),
  .exc_valid(exc_valid), .exc_code(exc_code), .owb_we(owb_we), .wr_en(wr_en),
  .ret_valid(ret_valid)
);

// File: tb/rwc_window_ctrl_test.sv
module rwc_window_ctrl_test;
  localparam int NAREG = 64;
  localparam int NG = 16;
  localparam int GW = 4;
  localparam int PW = 6;

  typedef struct packed {
    logic [GW-1:0] base;
    logic [NG-1:0] start;
    logic          exc;
    logic [3:0]    code;
    logic [31:0]   epc;
    logic          owe;
    logic [GW-1:0] owb;
    logic          wen;
    logic [PW-1:0] widx;
    logic [31:0]   wdata;
    logic          rv;
    logic [31:0]   rpc;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [2:0] op_code = '0;
  logic [3:0] op_s = '0;
  logic [11:0] op_imm = '0;
  logic [31:0] op_sp = '0, op_a0 = '0, op_pc = '0;
  logic st_woe = 1'b1, st_excm = 1'b0;
  logic [1:0] st_callinc = '0;
  logic [GW-1:0] st_owb = '0;
  logic [3:0] map_vidx = '0;
  logic [PW-1:0] map_pidx, wr_idx;
  logic [GW-1:0] win_base, owb_val;
  logic [NG-1:0] win_start;
  logic exc_valid, owb_we, wr_en, ret_valid;
  logic [3:0] exc_code;
  logic [31:0] exc_pc, wr_data, ret_pc;

  int checks = 0;
  int errors = 0;
  item_t exp_q[$];
  int    req_q[$];
  logic  armed = 1'b0;
  logic [GW-1:0] m_base = '0;
  logic [NG-1:0] m_start = 16'h0001;

  always #4 clk = ~clk; // 125 MHz

  rwc_window_ctrl #(.NAREG(NAREG)) uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code), .op_s(op_s),
    .op_imm(op_imm), .op_sp(op_sp), .op_a0(op_a0), .op_pc(op_pc), .st_woe(st_woe),
    .st_excm(st_excm), .st_callinc(st_callinc), .st_owb(st_owb), .map_vidx(map_vidx),
    .map_pidx(map_pidx), .win_base(win_base), .win_start(win_start),
    .exc_valid(exc_valid), .exc_code(exc_code), .exc_pc(exc_pc), .owb_we(owb_we),
    .owb_val(owb_val), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .ret_valid(ret_valid), .ret_pc(ret_pc)
  );

  function automatic logic live(int g);
    return m_start[g & 15];
  endfunction

  // monitor: compares the result of the op captured at the previous edge
  always @(negedge clk) begin
    if (armed && exp_q.size() > 0) begin
      item_t e, g;
      int r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      g = '{win_base, win_start, exc_valid, exc_code, exc_pc, owb_we, owb_val,
            wr_en, wr_idx, wr_data, ret_valid, ret_pc};
      checks++;
      if (g !== e) begin
        errors++;
        $display("FAIL R%0d got %h exp %h", r, g, e);
      end
    end
    armed = op_valid;
  end

  // driver: models the requirements, queues the expectation, drives pins
  task automatic issue(input int op, input int s, input int imm, input logic [31:0] sp,
                       input logic [31:0] a0, input logic [31:0] pc, input logic woe,
                       input logic excm, input int cinc, input int owb, input int req);
    item_t e;
    logic ok;
    e = '0;
    ok = woe && !excm;
    case (op)
      1: begin // R3 / R4
        if (s > 3 || !ok) begin e.exc = 1; e.code = 1; end
        else begin
          e.wen = 1;
          e.widx = PW'((int'(m_base) * 4 + cinc * 4 + s) & 63);
          e.wdata = sp - 32'(imm * 8);
          m_base = GW'((int'(m_base) + cinc) & 15);
          m_start[m_base] = 1'b1;
        end
      end
      2: if (ok) begin // R5 / R6
        int n;
        n = 0;
        for (int k = 1; k <= (imm & 3); k++)
          if (n == 0 && live(int'(m_base) + k)) n = k;
        if (n != 0) begin
          int m;
          m = (int'(m_base) + n) & 15;
          e.exc = 1; e.owe = 1; e.owb = m_base;
          e.code = live(m + 1) ? 4'd3 : live(m + 2) ? 4'd4 : 4'd5;
          m_base = GW'(m);
        end
      end
      3: begin // R7 / R8 / R9
        int n, mm;
        n = int'(a0[31:30]);
        mm = live(int'(m_base) + 15) ? 1 : live(int'(m_base) + 14) ? 2 :
             live(int'(m_base) + 13) ? 3 : 0;
        if (n == 0 || (mm != 0 && mm != n) || !ok) begin e.exc = 1; e.code = 1; end
        else begin
          int nb;
          nb = (int'(m_base) + 16 - n) & 15;
          if (live(nb)) begin
            m_start[m_base] = 1'b0;
            e.rv = 1; e.rpc = {pc[31:30], a0[29:0]};
          end else begin
            e.exc = 1; e.owe = 1; e.owb = m_base; e.code = 4'(5 + n);
          end
          m_base = GW'(nb);
        end
      end
      4: begin // R11
        int r;
        r = ((imm & 8) != 0) ? (imm & 15) - 16 : (imm & 15);
        m_base = GW'((int'(m_base) + r + 16) & 15);
      end
      5: m_base = GW'(owb);
      6: if (!live(int'(m_base) + 15) && !live(int'(m_base) + 14) && !live(int'(m_base) + 13)) begin
        e.exc = 1; e.code = 2; // R10
      end
      7: m_base = GW'(imm & 15);
      default: ;
    endcase
    if (e.exc) e.epc = pc;
    e.base = m_base;
    e.start = m_start;
    @(posedge clk);
    #2;
    exp_q.push_back(e);
    req_q.push_back(req);
    op_valid = 1'b1; op_code = 3'(op); op_s = 4'(s); op_imm = 12'(imm);
    op_sp = sp; op_a0 = a0; op_pc = pc; st_woe = woe; st_excm = excm;
    st_callinc = 2'(cinc); st_owb = GW'(owb);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
      op_valid = 1'b0;
      op_code = 3'(i + 1); op_s = 4'hF; op_imm = 12'hFFF; // junk while idle
    end
  endtask

  task automatic check_map(input int v, input int expv, input int req);
    map_vidx = 4'(v);
    #1;
    checks++;
    if (map_pidx !== PW'(expv)) begin
      errors++;
      $display("FAIL R%0d map got %0d exp %0d", req, map_pidx, expv);
    end
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #3;
    // R1: reset state
    checks++;
    if (win_base !== 0 || win_start !== 16'h0001 || exc_valid || wr_en || ret_valid) begin
      errors++;
      $display("FAIL R1 got base %0d mask %h exp 0 0001", win_base, win_start);
    end
    check_map(5, 5, 2);                                    // R2
    issue(7, 0, 15, 0, 0, 32'h100, 1, 0, 0, 0, 11);        // R11 set base 15
    idle(1);
    check_map(7, 3, 2);                                    // R2 wrap: 60+7 mod 64
    issue(7, 0, 0, 0, 0, 32'h104, 1, 0, 0, 0, 11);
    // R4: legal entry, callinc 1, s 1
    issue(1, 1, 2, 32'h1000, 0, 32'h200, 1, 0, 1, 0, 4);
    // R3: illegal entry variants
    issue(1, 4, 2, 32'h1000, 0, 32'h204, 1, 0, 1, 0, 3);
    issue(1, 1, 2, 32'h1000, 0, 32'h208, 0, 0, 1, 0, 3);
    issue(1, 1, 2, 32'h1000, 0, 32'h20C, 1, 1, 1, 0, 3);
    // R4: entry callinc 2 to base 3
    issue(1, 0, 5, 32'h2000, 0, 32'h210, 1, 0, 2, 0, 4);
    // R8: clean returns n=2 then n=1
    issue(3, 0, 0, 0, 32'h8000_0ABC, 32'hC000_0300, 1, 0, 0, 0, 8);
    issue(3, 0, 0, 0, 32'h4012_3456, 32'h4000_0304, 1, 0, 0, 0, 8);
    // R9: underflow n=1, then R11 restore
    issue(3, 0, 0, 0, 32'h4000_0010, 32'h308, 1, 0, 0, 0, 9);
    issue(5, 0, 0, 0, 0, 32'h30C, 1, 0, 0, 0, 11);
    // R7: n=0, mode wrong, mismatch
    issue(3, 0, 0, 0, 32'h0000_0010, 32'h310, 1, 0, 0, 0, 7);
    issue(3, 0, 0, 0, 32'h4000_0010, 32'h314, 1, 1, 0, 0, 7);
    issue(1, 0, 0, 32'h3000, 0, 32'h318, 1, 0, 1, 0, 4);
    issue(3, 0, 0, 0, 32'h8000_0010, 32'h31C, 1, 0, 0, 0, 7);
    // R10: stack-move pass and fail
    issue(6, 0, 0, 0, 0, 32'h400, 1, 0, 0, 0, 10);
    issue(7, 0, 5, 0, 0, 32'h404, 1, 0, 0, 0, 11);
    issue(6, 0, 0, 0, 0, 32'h408, 1, 0, 0, 0, 10);
    // R5: no live group in range, and gating
    issue(2, 0, 3, 0, 0, 32'h500, 1, 0, 0, 0, 5);
    issue(7, 0, 14, 0, 0, 32'h504, 1, 0, 0, 0, 11);
    issue(2, 0, 3, 0, 0, 32'h508, 1, 1, 0, 0, 5);
    issue(2, 0, 0, 0, 0, 32'h50C, 1, 0, 0, 0, 5);
    // R6: overflow-4 from base 14
    issue(2, 0, 3, 0, 0, 32'h510, 1, 0, 0, 0, 6);
    // R6: overflow-12 and overflow-8
    issue(7, 0, 9, 0, 0, 32'h514, 1, 0, 0, 0, 11);
    issue(1, 0, 0, 32'h40, 0, 32'h518, 1, 0, 0, 0, 4);
    issue(7, 0, 7, 0, 0, 32'h51C, 1, 0, 0, 0, 11);
    issue(2, 0, 1, 0, 0, 32'h520, 1, 0, 0, 0, 5);
    issue(2, 0, 3, 0, 0, 32'h524, 1, 0, 0, 0, 6);
    issue(7, 0, 11, 0, 0, 32'h528, 1, 0, 0, 0, 11);
    issue(1, 0, 0, 32'h40, 0, 32'h52C, 1, 0, 0, 0, 4);
    issue(7, 0, 7, 0, 0, 32'h530, 1, 0, 0, 0, 11);
    issue(2, 0, 2, 0, 0, 32'h534, 1, 0, 0, 0, 6);
    // R11: signed rotate with wrap
    issue(4, 0, 14, 0, 0, 32'h600, 1, 0, 0, 0, 11);
    issue(4, 0, 7, 0, 0, 32'h604, 1, 0, 0, 0, 11);
    issue(4, 0, 8, 0, 0, 32'h608, 1, 0, 0, 0, 11);
    issue(7, 0, 15, 0, 0, 32'h60C, 1, 0, 0, 0, 11);
    issue(4, 0, 3, 0, 0, 32'h610, 1, 0, 0, 0, 11);
    // R12: op code 0 and idle cycles
    issue(0, 3, 5, 32'hFF, 32'hFF, 32'h700, 1, 0, 3, 7, 12);
    idle(3);
    // R2 with R11 in one cycle: map before and after the rotate edge
    map_vidx = 4'd13;
    issue(4, 0, 1, 0, 0, 32'h800, 1, 0, 0, 0, 11);
    #3;
    check_map(13, 21, 2);
    idle(1);
    #1;
    check_map(13, 25, 2);
    idle(2);
    @(negedge clk);
    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule